// File: doc/BRIEF.md
# DC Intra Predictor with Boundary Smoothing

This block builds the DC-mode prediction for one square luma block whose side is 4, 8, 16 or 32 samples, using 8-bit samples. On a start pulse it reads the row of reconstructed samples above the block and the column to its left through a read port, one sample per clock. It sums them and forms their rounded mean, called the DC value.

It then emits the predicted block one pixel per clock in raster order, with the pixel's column and row beside each value. Pixels away from the top and left edges take the DC value unchanged. For block sides up to 16, the top-left corner, the rest of the top row and the rest of the left column are smoothed toward the adjacent neighbour sample using fixed weights that need only shifts and adds. A one-cycle done pulse closes the block.

The surrounding encoder owns the neighbour storage and answers the read port in the same cycle, with no registered delay. Fetching the neighbours, substituting missing ones and chroma handling all happen outside this block.

Top module: `dcIntraPred`

## Requirements
- R1: While reset is asserted and right after it, pixValid, done, busy and nbrRdEn are all 0.
- R2: sizeSel encodes the block side N as 0→4, 1→8, 2→16, 3→32. After a start accepted at a clock edge, the block reads for 2N cycles: above samples 0..N-1 (nbrRdSide=0), then left samples 0..N-1 (nbrRdSide=1). The first pixValid is seen 2N+2 edges after the start edge.
- R3: The DC value equals (sum of the N above and N left samples + N) >> (log2 N + 1).
- R4: Every pixel with x≠0 and y≠0 equals the DC value.
- R5: For N≤16, pixel (0,0) equals (left[0] + 2·DC + above[0] + 2) >> 2.
- R6: For N≤16, pixel (x,0) with x≥1 equals (above[x] + 3·DC + 2) >> 2.
- R7: For N≤16, pixel (0,y) with y≥1 equals (left[y] + 3·DC + 2) >> 2.
- R8: For N=32, every pixel, the edges included, equals the DC value.
- R9: The block emits exactly N·N pixels on consecutive cycles in raster order: x runs 0..N-1 within each row, and rows run y=0..N-1.
- R10: done is high for exactly one cycle, the cycle after the last pixValid, and busy is 0 after it.
- R11: A start while busy is ignored. The running block completes unchanged and no second block follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block (taken only when idle) |
| sizeSel | input | 2 | Block side code: 0→4, 1→8, 2→16, 3→32 |
| nbrRdEn | output | 1 | Neighbour read request |
| nbrRdSide | output | 1 | 0 = above row, 1 = left column |
| nbrRdIdx | output | 5 | Neighbour index along the chosen side |
| nbrRdData | input | 8 | Neighbour sample, valid in the same cycle as the request |
| busy | output | 1 | A block is in progress |
| pixValid | output | 1 | pixData, pixX and pixY are valid |
| pixX | output | 5 | Column of the current pixel |
| pixY | output | 5 | Row of the current pixel |
| pixData | output | 8 | Predicted sample |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The bench builds the block with its default parameters: 8-bit samples, sides up to 32, and smoothing up to side 16. With these values all four size codes can be reached, including the largest, where smoothing is switched off. All-255 neighbours at side 32 drive the sum to its maximum, exercising the widest accumulator value and the rounding at the top of the range. Smaller sides with ramps and pseudo-random data cover the three smoothing cases. A start injected mid-stream exercises the rule that a start while busy is ignored.

// File: rtl/dcPredPkg.sv
package dcPredPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_DCAVG,
    ST_STREAM,
    ST_FINISH
  } ctrlState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic clrSum;
    logic addSum;
    logic capTop0;
    logic capLeft0;
    logic loadDc;
    logic emit;
  } dpStrobe_t;

endpackage

// File: rtl/dcPredCtrl.sv
module dcPredCtrl
  import dcPredPkg::*;
#(
  parameter int MAX_LOG2 = 5,
  localparam int CNT_W = MAX_LOG2 + 1,
  localparam int LOG_W = $clog2(MAX_LOG2 + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          sizeSel,
  output dpStrobe_t           strobe,
  output logic [MAX_LOG2-1:0] curX,
  output logic [MAX_LOG2-1:0] curY,
  output logic [LOG_W-1:0]    logN,
  output logic                nbrRdEn,
  output logic                nbrRdSide,
  output logic [MAX_LOG2-1:0] nbrRdIdx,
  output logic                busy,
  output logic                done
);

  ctrlState_t st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   nN;
  logic [CNT_W:0]   lastAcc;
  logic             leftPhase;
  logic             lastX;
  logic             lastY;

  assign nN        = (CNT_W+1)'(1) << logN;
  assign lastAcc   = (nN << 1) - (CNT_W+1)'(1);
  assign leftPhase = {1'b0, cnt} >= nN;
  assign lastX     = (CNT_W+1)'(curX) == nN - (CNT_W+1)'(1);
  assign lastY     = (CNT_W+1)'(curY) == nN - (CNT_W+1)'(1);
  assign busy      = (st != ST_IDLE);

  always_comb begin
    strobe    = '0;
    nbrRdEn   = 1'b0;
    nbrRdSide = 1'b0;
    nbrRdIdx  = '0;
    case (st)
      ST_IDLE: strobe.clrSum = start;
      ST_ACCUM: begin
        strobe.addSum   = 1'b1;
        strobe.capTop0  = (cnt == '0);
        strobe.capLeft0 = ({1'b0, cnt} == nN);
        nbrRdEn         = 1'b1;
        nbrRdSide       = leftPhase;
        nbrRdIdx        = cnt[MAX_LOG2-1:0] & MAX_LOG2'(nN - (CNT_W+1)'(1));
      end
      ST_DCAVG: strobe.loadDc = 1'b1;
      ST_STREAM: begin
        strobe.emit = 1'b1;
        if (curY == '0 && curX != '0) begin
          nbrRdEn  = 1'b1;
          nbrRdIdx = curX;
        end else if (curX == '0 && curY != '0) begin
          nbrRdEn   = 1'b1;
          nbrRdSide = 1'b1;
          nbrRdIdx  = curY;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      curX <= '0;
      curY <= '0;
      logN <= '0;
      done <= 1'b0;
    end else begin
      done <= (st == ST_FINISH);
      case (st)
        ST_IDLE: if (start) begin
          logN <= LOG_W'(sizeSel) + LOG_W'(2);
          cnt  <= '0;
          st   <= ST_ACCUM;
        end
        ST_ACCUM: begin
          cnt <= cnt + CNT_W'(1);
          if ({1'b0, cnt} == lastAcc) st <= ST_DCAVG;
        end
        ST_DCAVG: begin
          curX <= '0;
          curY <= '0;
          st   <= ST_STREAM;
        end
        ST_STREAM: begin
          if (lastX) begin
            curX <= '0;
            if (lastY) st <= ST_FINISH;
            else curY <= curY + MAX_LOG2'(1);
          end else begin
            curX <= curX + MAX_LOG2'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: size latched at an accepted start stays put for the whole block
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> $stable(logN));

  // R2: neighbour index never leaves the current block side
  assert_read_idx_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    nbrRdEn |-> ((CNT_W+1)'(nbrRdIdx) < nN));

endmodule

// File: rtl/dcPredDatapath.sv
module dcPredDatapath
  import dcPredPkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_LOG2 = 5,
  parameter int FILT_MAX_LOG2 = 4,
  localparam int SUM_W = PIX_W + MAX_LOG2 + 1,
  localparam int LOG_W = $clog2(MAX_LOG2 + 2),
  localparam int EXT_W = PIX_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [MAX_LOG2-1:0] curX,
  input  logic [MAX_LOG2-1:0] curY,
  input  logic [LOG_W-1:0]    logN,
  input  logic [PIX_W-1:0]    nbrRdData,
  output logic                pixValid,
  output logic [MAX_LOG2-1:0] pixX,
  output logic [MAX_LOG2-1:0] pixY,
  output logic [PIX_W-1:0]    pixData
);

  logic [SUM_W-1:0] sum;
  logic [SUM_W:0]   sumRnd;
  logic [PIX_W-1:0] dcVal;
  logic [PIX_W-1:0] top0;
  logic [PIX_W-1:0] left0;
  logic [EXT_W-1:0] dbl;
  logic [EXT_W-1:0] tri3;
  logic [EXT_W-1:0] cornerSum;
  logic [EXT_W-1:0] edgeSum;
  logic [PIX_W-1:0] pixNext;
  logic             filtOn;
  logic [MAX_LOG2:0] nN;

  assign nN     = (MAX_LOG2+1)'(1) << logN;
  assign sumRnd = (SUM_W+1)'(sum) + (SUM_W+1)'(nN);
  assign filtOn = (32'(logN) <= FILT_MAX_LOG2);

  // shift-and-add weights
  assign dbl       = {1'b0, dcVal, 1'b0};
  assign tri3      = dbl + {2'b00, dcVal};
  assign cornerSum = {2'b00, left0} + {2'b00, top0} + dbl + EXT_W'(2);
  assign edgeSum   = {2'b00, nbrRdData} + tri3 + EXT_W'(2);

  always_comb begin
    pixNext = dcVal;
    if (filtOn) begin
      if (curX == '0 && curY == '0)      pixNext = cornerSum[EXT_W-1:2];
      else if (curX == '0 || curY == '0) pixNext = edgeSum[EXT_W-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum      <= '0;
      dcVal    <= '0;
      top0     <= '0;
      left0    <= '0;
      pixValid <= 1'b0;
      pixX     <= '0;
      pixY     <= '0;
      pixData  <= '0;
    end else begin
      if (strobe.clrSum)      sum <= '0;
      else if (strobe.addSum) sum <= sum + SUM_W'(nbrRdData);
      if (strobe.capTop0)  top0  <= nbrRdData;
      if (strobe.capLeft0) left0 <= nbrRdData;
      if (strobe.loadDc)   dcVal <= PIX_W'(sumRnd >> (logN + LOG_W'(1)));
      pixValid <= strobe.emit;
      if (strobe.emit) begin
        pixX    <= curX;
        pixY    <= curY;
        pixData <= pixNext;
      end
    end
  end

  // R9: within a row, consecutive pixels step x by one on back-to-back cycles
  assert_raster_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && pixX != '0 |-> $past(pixValid) && pixX == $past(pixX) + MAX_LOG2'(1)
                               && pixY == $past(pixY));

  // R9: coordinates stay inside the block
  assert_pix_in_bounds_R9: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> ((MAX_LOG2+1)'(pixX) < nN) && ((MAX_LOG2+1)'(pixY) < nN));

  // R4: interior output matches the averaged value held since the averaging step
  assert_interior_dc_R4: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && pixX != '0 && pixY != '0 |-> pixData == dcVal);

endmodule

// File: rtl/dcIntraPred.sv
module dcIntraPred
  import dcPredPkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_LOG2 = 5,
  parameter int FILT_MAX_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          sizeSel,
  output logic                nbrRdEn,
  output logic                nbrRdSide,
  output logic [MAX_LOG2-1:0] nbrRdIdx,
  input  logic [PIX_W-1:0]    nbrRdData,
  output logic                busy,
  output logic                pixValid,
  output logic [MAX_LOG2-1:0] pixX,
  output logic [MAX_LOG2-1:0] pixY,
  output logic [PIX_W-1:0]    pixData,
  output logic                done
);

  localparam int LOG_W = $clog2(MAX_LOG2 + 2);

  dpStrobe_t           strobe;
  logic [MAX_LOG2-1:0] curX;
  logic [MAX_LOG2-1:0] curY;
  logic [LOG_W-1:0]    logN;

  dcPredCtrl #(.MAX_LOG2(MAX_LOG2)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel),
    .strobe(strobe), .curX(curX), .curY(curY), .logN(logN),
    .nbrRdEn(nbrRdEn), .nbrRdSide(nbrRdSide), .nbrRdIdx(nbrRdIdx),
    .busy(busy), .done(done)
  );

  dcPredDatapath #(.PIX_W(PIX_W), .MAX_LOG2(MAX_LOG2), .FILT_MAX_LOG2(FILT_MAX_LOG2)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curX(curX), .curY(curY),
    .logN(logN), .nbrRdData(nbrRdData), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .pixData(pixData)
  );

  // R10: done follows a pixel and never coincides with one
  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(pixValid) && !pixValid);

  // R10: done is a single-cycle pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/sim_dcIntraPred.sv
module sim_dcIntraPred;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] sizeSel = '0;
  logic       nbrRdEn, nbrRdSide, busy, pixValid, done;
  logic [4:0] nbrRdIdx, pixX, pixY;
  logic [7:0] nbrRdData, pixData;

  logic [7:0] aboveMem [32];
  logic [7:0] leftMem  [32];

  int totalCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign nbrRdData = nbrRdSide ? leftMem[nbrRdIdx] : aboveMem[nbrRdIdx];

  dcIntraPred u0 (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel),
    .nbrRdEn(nbrRdEn), .nbrRdSide(nbrRdSide), .nbrRdIdx(nbrRdIdx),
    .nbrRdData(nbrRdData), .busy(busy), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .pixData(pixData), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 flat, 1 ramp, 2 pseudo-random, 3 all max, 4 descending
  task automatic fillNbr(input int kind, input int base);
    for (int i = 0; i < 32; i++) begin
      case (kind)
        0: begin aboveMem[i] = 8'(base); leftMem[i] = 8'(base); end
        1: begin aboveMem[i] = 8'(base + 7*i); leftMem[i] = 8'(base + 3*i + 11); end
        2: begin aboveMem[i] = 8'($urandom); leftMem[i] = 8'($urandom); end
        3: begin aboveMem[i] = 8'hFF; leftMem[i] = 8'hFF; end
        default: begin aboveMem[i] = 8'(255 - 5*i); leftMem[i] = 8'(200 - 6*i); end
      endcase
    end
  endtask

  // drives one block and checks every pixel, latency and done
  task automatic runBlock(input int sel, input bit poke);
    int n = 4 << sel;
    int lg = sel + 2;
    int sum = 0;
    int dc, expV, cyc, got, ex, ey;
    string req;
    for (int i = 0; i < n; i++) sum += aboveMem[i] + leftMem[i];
    dc = (sum + n) >> (lg + 1);
    cyc = 0; got = 0; ex = 0; ey = 0;
    @(negedge clk);
    start = 1'b1;
    sizeSel = 2'(sel);
    while (got < n*n && cyc < n*n + 2*n + 50) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 2*n + 8) begin
        start = 1'b1;
        sizeSel = 2'((sel + 1) % 4);
      end
      if (pixValid) begin
        if (got == 0) check(cyc == 2*n + 3, "R2 latency", cyc, 2*n + 3);
        check(pixX == 5'(ex) && pixY == 5'(ey), "R9 order", pixX*100 + pixY, ex*100 + ey);
        if (n == 32) begin
          expV = dc; req = "R8 no filter";
        end else if (ex == 0 && ey == 0) begin
          expV = (leftMem[0] + 2*dc + aboveMem[0] + 2) >> 2; req = "R5 corner";
        end else if (ey == 0) begin
          expV = (aboveMem[ex] + 3*dc + 2) >> 2; req = "R6 top row";
        end else if (ex == 0) begin
          expV = (leftMem[ey] + 3*dc + 2) >> 2; req = "R7 left col";
        end else begin
          expV = dc; req = "R3 R4 interior";
        end
        check(int'(pixData) == expV, req, pixData, expV);
        got++;
        if (ex == n - 1) begin ex = 0; ey++; end else ex++;
      end else if (got > 0) begin
        check(1'b0, "R9 gap in stream", 0, 1);
      end
    end
    check(got == n*n, "R9 pixel count", got, n*n);
    @(negedge clk);
    check(done && !pixValid, "R10 done after last", {done, pixValid}, 2);
    @(negedge clk);
    check(!done && !busy, "R10 done single", {done, busy}, 0);
    if (poke) begin
      repeat (2*n + 10) begin
        @(negedge clk);
        check(!pixValid && !busy, "R11 no second block", {pixValid, busy}, 0);
      end
    end
  endtask

  task automatic testReset;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!pixValid && !done && !busy && !nbrRdEn, "R1 in reset",
          {pixValid, done, busy, nbrRdEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!pixValid && !done && !busy && !nbrRdEn, "R1 after reset",
          {pixValid, done, busy, nbrRdEn}, 0);
  endtask

  task automatic testFlat4;   fillNbr(0, 77);  runBlock(0, 1'b0); endtask
  task automatic testRamp8;   fillNbr(1, 3);   runBlock(1, 1'b0); endtask
  task automatic testRand16;  fillNbr(2, 0);   runBlock(2, 1'b0); endtask
  task automatic testDesc4;   fillNbr(4, 0);   runBlock(0, 1'b0); endtask
  task automatic testMax32;   fillNbr(3, 0);   runBlock(3, 1'b0); endtask
  task automatic testRand32;  fillNbr(2, 0);   runBlock(3, 1'b0); endtask
  task automatic testBusyStart; fillNbr(1, 40); runBlock(1, 1'b1); endtask
  task automatic testMax16;   fillNbr(3, 0);   runBlock(2, 1'b0); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    fillNbr(0, 0);
    testReset();
    testFlat4();
    testRamp8();
    testRand16();
    testDesc4();
    testMax32();
    testRand32();
    testBusyStart();
    testMax16();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule